// File: doc/BRIEF.md
# Prioritised Interrupt Vector Controller

This block sits between a small CPU and five interrupt sources: a non-maskable line, two external request lines, a timer underflow pulse and a conversion-done pulse. It conditions each source (edge capture or level sensing), screens the maskable requests with per-vector enables and a global enable, applies a fixed priority and a two-level nesting rule, and hands the CPU a vector address together with a one-cycle take pulse when the CPU reports an instruction boundary.

The CPU ends a handler with a return strobe. The controller tracks whether a peripheral handler, the non-maskable handler, or both (the latter preempting the former) are in service, and unwinds that state on each return. A wake indication tells the clock manager that an enabled request is waiting. It stays low while the global enable is low, even when a non-maskable request is still taken.

Top module: `irq_vector_ctrl`

## Requirements
- R1: An asserted reset (rst_n low) forces vec_addr_o to 12'hFFE, take_o to 0 and insvc_o to idle, overriding any handler in service, and discards all captured requests; the first clock after reset release only samples the lines, so no edge is captured on it.
- R2: A falling edge on nmi_n_i is captured and has the highest priority; it is taken with vector 12'hFFC whenever the non-maskable handler is not in service, which includes preempting a peripheral handler.
- R3: A non-maskable request arriving while the non-maskable handler is in service is held and taken only after that handler returns.
- R4: A maskable vector n (1 to 4) is taken only when no handler is in service, glb_en_i is 1 and vec_en_i[n-1] is 1; among several, the lowest n wins; its address is 12'hFF0 + 2*(n-1).
- R5: With ext1_level_i = 1, vector 1 requests for as long as ext1_n_i is low and nothing is captured, so a low pulse that ends before it can be taken is lost.
- R6: With ext1_level_i = 0, a falling edge on ext1_n_i is captured and raises vector 1 until it is taken.
- R7: Vector 2 captures a falling edge of ext2_i when ext2_rise_i = 0 and a rising edge when ext2_rise_i = 1; the opposite edge has no effect.
- R8: A rising edge of tmr_uf_i captures vector 3 and one of adc_done_i captures vector 4; a captured request is cleared only when it is taken.
- R9: A request is taken only in a cycle with boundary_i = 1 and reti_i = 0; take_o is then 1 for exactly the next cycle, with vec_addr_o holding the taken vector from then until the next take.
- R10: reti_i leaves the non-maskable handler back in the peripheral state when it had preempted one, otherwise idle; from the peripheral state it returns to idle.
- R11: wake_o is 1 exactly when glb_en_i is 1 and either a non-maskable request is captured or an enabled maskable request is present; it is 0 whenever glb_en_i is 0.
- R12: insvc_o encodes 2'b00 idle, 2'b01 peripheral handler, 2'b10 non-maskable handler; 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_n_i | input | 1 | Non-maskable request line, active low |
| ext1_n_i | input | 1 | External line group 1 request, active low |
| ext1_level_i | input | 1 | 1 selects level sensing for vector 1 |
| ext2_i | input | 1 | External line group 2 request |
| ext2_rise_i | input | 1 | Vector 2 edge select: 0 falling, 1 rising |
| tmr_uf_i | input | 1 | Timer underflow event |
| adc_done_i | input | 1 | Conversion complete event |
| glb_en_i | input | 1 | Global enable for maskable vectors |
| vec_en_i | input | 4 | Per-vector enables, bit n-1 for vector n |
| boundary_i | input | 1 | CPU is at an instruction boundary |
| reti_i | input | 1 | Return-from-interrupt strobe |
| vec_addr_o | output | 12 | Address of the last taken vector |
| take_o | output | 1 | One-cycle take-interrupt pulse |
| insvc_o | output | 2 | In-service level |
| wake_o | output | 1 | Wake-up indication |

## Verification
An edge applied before clock edge k is captured at k and can be taken at k+1, so take_o and vec_addr_o show it after k+1; a level request on vector 1 and the return strobe act at edge k itself, and wake_o follows the captured state and the level line with no further register. The bench drives inputs on the falling clock edge, advances a cycle model written from the requirements with the same inputs, and compares all four outputs at the next falling edge, so each result is read in the exact cycle it is due. Directed sequences bring out lost level pulses, held nested non-maskable requests, simultaneous maskable requests and a reset during a non-maskable handler.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

  localparam int unsigned NUM_MASK = 4;
  localparam int unsigned NUM_SRC  = NUM_MASK + 1;

  typedef enum logic [1:0] {
    INS_IDLE   = 2'b00,
    INS_PERIPH = 2'b01,
    INS_NMI    = 2'b10
  } ins_t;

endpackage

// File: rtl/irq_line_cond.sv
// Conditions one request line: edge capture with a hold latch, or level pass-through.
module irq_line_cond #(
  parameter bit ACT_LOW   = 1'b1,
  parameter bit HAS_LEVEL = 1'b0,
  parameter bit HAS_SEL   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic arm_i,
  input  logic rise_sel_i,
  input  logic level_sel_i,
  input  logic clr_i,
  output logic req_o
);

  logic samp_q;
  logic pend_q;
  logic pend_d;
  logic pend_en;
  logic rise_mode;
  logic lvl_mode;
  logic edge_hit;

  if (HAS_SEL) begin : g_sel
    assign rise_mode = rise_sel_i;
  end else begin : g_fixed
    logic unused_sel;
    assign unused_sel = rise_sel_i;
    assign rise_mode  = ~ACT_LOW;
  end

  if (HAS_LEVEL) begin : g_lvl
    assign lvl_mode = level_sel_i;
  end else begin : g_nolvl
    logic unused_lvl;
    assign unused_lvl = level_sel_i;
    assign lvl_mode   = 1'b0;
  end

  always_comb begin
    if (rise_mode) edge_hit = line_i & ~samp_q;
    else           edge_hit = ~line_i & samp_q;
    edge_hit = edge_hit & arm_i & ~lvl_mode;
    pend_d   = (pend_q & ~clr_i) | edge_hit;
    pend_en  = edge_hit | clr_i;
    if (lvl_mode) req_o = ACT_LOW ? ~line_i : line_i;
    else          req_o = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= ACT_LOW;
      pend_q <= 1'b0;
    end else begin
      samp_q <= line_i;
      if (pend_en) pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/irq_arbiter.sv
// Picks the request to take this cycle under priority and nesting rules.
module irq_arbiter
  import irq_vec_pkg::*;
#(
  parameter int unsigned NM = NUM_MASK
) (
  input  logic          nmi_req_i,
  input  logic [NM-1:0] mask_req_i,
  input  logic [NM-1:0] mask_en_i,
  input  logic          glb_en_i,
  input  ins_t          ins_i,
  input  logic          boundary_i,
  input  logic          reti_i,
  output logic          take_nmi_o,
  output logic [NM-1:0] grant_o,
  output logic          wake_o
);

  logic [NM-1:0] elig;
  logic          slot_open;
  logic          found;

  always_comb begin
    elig       = mask_req_i & mask_en_i & {NM{glb_en_i}};
    slot_open  = boundary_i & ~reti_i;
    take_nmi_o = slot_open & nmi_req_i & (ins_i != INS_NMI);
    grant_o    = '0;
    found      = 1'b0;
    for (int i = 0; i < int'(NM); i++) begin
      if (slot_open && !take_nmi_o && (ins_i == INS_IDLE) && elig[i] && !found) begin
        grant_o[i] = 1'b1;
        found      = 1'b1;
      end
    end
    wake_o = glb_en_i & (nmi_req_i | (|elig));
  end

endmodule

// File: rtl/irq_nest_ctrl.sv
// Holds the in-service level, the preempted-peripheral flag and the vector output.
module irq_nest_ctrl
  import irq_vec_pkg::*;
#(
  parameter int unsigned          NM       = NUM_MASK,
  parameter int unsigned          ADDR_W   = 12,
  parameter logic [ADDR_W-1:0]    VEC_BASE = 12'hFF0,
  parameter logic [ADDR_W-1:0]    NMI_VEC  = 12'hFFC,
  parameter logic [ADDR_W-1:0]    RST_VEC  = 12'hFFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_nmi_i,
  input  logic [NM-1:0]     grant_i,
  input  logic              reti_i,
  output ins_t              ins_o,
  output logic              take_o,
  output logic [ADDR_W-1:0] vec_o
);

  ins_t              ins_q, ins_d;
  logic              pre_q, pre_d;
  logic              take_q, take_d;
  logic [ADDR_W-1:0] vec_q, vec_d;
  logic              state_en;

  always_comb begin
    ins_d    = ins_q;
    pre_d    = pre_q;
    vec_d    = vec_q;
    take_d   = take_nmi_i | (|grant_i);
    state_en = reti_i | take_d;
    if (reti_i) begin
      unique case (ins_q)
        INS_NMI: begin
          ins_d = pre_q ? INS_PERIPH : INS_IDLE;
          pre_d = 1'b0;
        end
        INS_PERIPH: ins_d = INS_IDLE;
        default:    ins_d = ins_q;
      endcase
    end else if (take_nmi_i) begin
      pre_d = (ins_q == INS_PERIPH);
      ins_d = INS_NMI;
      vec_d = NMI_VEC;
    end else if (|grant_i) begin
      ins_d = INS_PERIPH;
      for (int i = 0; i < int'(NM); i++) begin
        if (grant_i[i]) vec_d = VEC_BASE + ADDR_W'(2 * i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_q  <= INS_IDLE;
      pre_q  <= 1'b0;
      take_q <= 1'b0;
      vec_q  <= RST_VEC;
    end else begin
      take_q <= take_d;
      if (state_en) begin
        ins_q <= ins_d;
        pre_q <= pre_d;
        vec_q <= vec_d;
      end
    end
  end

  assign ins_o  = ins_q;
  assign take_o = take_q;
  assign vec_o  = vec_q;

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vec_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] VEC_BASE = 12'hFF0,
  parameter logic [ADDR_W-1:0] NMI_VEC  = 12'hFFC,
  parameter logic [ADDR_W-1:0] RST_VEC  = 12'hFFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_n_i,
  input  logic              ext1_n_i,
  input  logic              ext1_level_i,
  input  logic              ext2_i,
  input  logic              ext2_rise_i,
  input  logic              tmr_uf_i,
  input  logic              adc_done_i,
  input  logic              glb_en_i,
  input  logic [3:0]        vec_en_i,
  input  logic              boundary_i,
  input  logic              reti_i,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic              take_o,
  output logic [1:0]        insvc_o,
  output logic              wake_o
);

  localparam int unsigned NM = NUM_MASK;
  localparam int unsigned NS = NUM_SRC;

  logic [NS-1:0] line;
  logic [NS-1:0] req;
  logic [NS-1:0] clr;
  logic [NM-1:0] grant;
  logic          take_nmi;
  logic          arm_q;
  ins_t          ins;

  // Source index 0 is the non-maskable line, index n is maskable vector n.
  assign line = {adc_done_i, tmr_uf_i, ext2_i, ext1_n_i, nmi_n_i};
  assign clr  = {grant, take_nmi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= 1'b0;
    else        arm_q <= 1'b1;
  end

  for (genvar g = 0; g < int'(NS); g++) begin : g_src
    localparam bit AL = (g <= 2);
    localparam bit HL = (g == 1);
    localparam bit HS = (g == 2);
    irq_line_cond #(
      .ACT_LOW  (AL),
      .HAS_LEVEL(HL),
      .HAS_SEL  (HS)
    ) u_cond (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_i     (line[g]),
      .arm_i      (arm_q),
      .rise_sel_i (ext2_rise_i),
      .level_sel_i(ext1_level_i),
      .clr_i      (clr[g]),
      .req_o      (req[g])
    );
  end

  irq_arbiter #(.NM(NM)) u_arb (
    .nmi_req_i (req[0]),
    .mask_req_i(req[NS-1:1]),
    .mask_en_i (vec_en_i),
    .glb_en_i  (glb_en_i),
    .ins_i     (ins),
    .boundary_i(boundary_i),
    .reti_i    (reti_i),
    .take_nmi_o(take_nmi),
    .grant_o   (grant),
    .wake_o    (wake_o)
  );

  irq_nest_ctrl #(
    .NM      (NM),
    .ADDR_W  (ADDR_W),
    .VEC_BASE(VEC_BASE),
    .NMI_VEC (NMI_VEC),
    .RST_VEC (RST_VEC)
  ) u_nest (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_nmi_i(take_nmi),
    .grant_i   (grant),
    .reti_i    (reti_i),
    .ins_o     (ins),
    .take_o    (take_o),
    .vec_o     (vec_addr_o)
  );

  assign insvc_o = ins;

endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int unsigned       ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] NMI_VEC = 12'hFFC
) (
  input logic              clk,
  input logic              rst_n,
  input logic              glb_en_i,
  input logic              boundary_i,
  input logic              reti_i,
  input logic [ADDR_W-1:0] vec_addr_o,
  input logic              take_o,
  input logic [1:0]        insvc_o,
  input logic              wake_o
);

  assert_ins_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
    insvc_o != 2'b11);

  assert_nmi_vec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && insvc_o == 2'b10) |-> vec_addr_o == NMI_VEC);

  assert_nmi_no_self_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && vec_addr_o == NMI_VEC) |-> $past(insvc_o) != 2'b10);

  assert_mask_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && vec_addr_o != NMI_VEC) |-> ($past(insvc_o) == 2'b00 && $past(glb_en_i)));

  assert_take_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> ($past(boundary_i) && !$past(reti_i)));

  assert_periph_ret_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && insvc_o == 2'b01) |=> insvc_o == 2'b00);

  assert_wake_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en_i |-> !wake_o);

endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .NMI_VEC(NMI_VEC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .glb_en_i  (glb_en_i),
  .boundary_i(boundary_i),
  .reti_i    (reti_i),
  .vec_addr_o(vec_addr_o),
  .take_o    (take_o),
  .insvc_o   (insvc_o),
  .wake_o    (wake_o)
);

// File: tb/tb_irq_vector_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vector_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        nmi_n, ext1_n, ext1_lvl, ext2, ext2_rise, tmr, adc, glb, bnd, reti;
  logic [3:0]  en;
  logic [11:0] vec_addr;
  logic        take, wake;
  logic [1:0]  insvc;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // cycle model state
  logic [4:0]  m_pend, m_samp;
  logic        m_arm, m_pre, m_take;
  logic [1:0]  m_ins;
  logic [11:0] m_vec;

  always #5 clk = ~clk;

  irq_vector_ctrl dut (
    .clk(clk), .rst_n(rst_n), .nmi_n_i(nmi_n), .ext1_n_i(ext1_n),
    .ext1_level_i(ext1_lvl), .ext2_i(ext2), .ext2_rise_i(ext2_rise),
    .tmr_uf_i(tmr), .adc_done_i(adc), .glb_en_i(glb), .vec_en_i(en),
    .boundary_i(bnd), .reti_i(reti), .vec_addr_o(vec_addr), .take_o(take),
    .insvc_o(insvc), .wake_o(wake)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] raw_lines();
    return {adc, tmr, ext2, ext1_n, nmi_n};
  endfunction

  function automatic logic [4:0] model_req();
    logic [4:0] r;
    r = m_pend;
    if (ext1_lvl) r[1] = ~ext1_n;
    return r;
  endfunction

  function automatic logic model_wake();
    logic [4:0] r;
    r = model_req();
    return glb & (r[0] | (|(r[4:1] & en)));
  endfunction

  task automatic model_step();
    logic [4:0] raw, ev, r, clr;
    logic [3:0] elig, grant;
    logic       open_s, tn;
    if (!rst_n) begin
      m_pend = '0; m_samp = 5'b00111; m_arm = 1'b0; m_pre = 1'b0;
      m_take = 1'b0; m_ins = 2'b00; m_vec = 12'hFFE;
      return;
    end
    raw   = raw_lines();
    ev[0] = m_samp[0] & ~raw[0];
    ev[1] = ~ext1_lvl & m_samp[1] & ~raw[1];
    ev[2] = ext2_rise ? (~m_samp[2] & raw[2]) : (m_samp[2] & ~raw[2]);
    ev[3] = ~m_samp[3] & raw[3];
    ev[4] = ~m_samp[4] & raw[4];
    if (!m_arm) ev = '0;
    r      = model_req();
    elig   = r[4:1] & en & {4{glb}};
    open_s = bnd & ~reti;
    tn     = open_s & r[0] & (m_ins != 2'b10);
    grant  = '0;
    if (open_s && !tn && m_ins == 2'b00) begin
      for (int i = 0; i < 4; i++) if (elig[i] && grant == 4'd0) grant[i] = 1'b1;
    end
    clr    = {grant, tn};
    m_take = tn | (|grant);
    if (reti) begin
      if (m_ins == 2'b10) begin m_ins = m_pre ? 2'b01 : 2'b00; m_pre = 1'b0; end
      else if (m_ins == 2'b01) m_ins = 2'b00;
    end else if (tn) begin
      m_pre = (m_ins == 2'b01); m_ins = 2'b10; m_vec = 12'hFFC;
    end else if (|grant) begin
      m_ins = 2'b01;
      for (int i = 0; i < 4; i++) if (grant[i]) m_vec = 12'hFF0 + 12'(2 * i);
    end
    m_pend = (m_pend & ~clr) | ev;
    m_samp = raw;
    m_arm  = 1'b1;
  endtask

  // Advance one cycle; inputs were set at the preceding falling edge.
  task automatic tick(input string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk({tag, " take"},  {31'd0, take},   {31'd0, m_take});
    chk({tag, " insvc"}, {30'd0, insvc},  {30'd0, m_ins});
    chk({tag, " vec"},   {20'd0, vec_addr}, {20'd0, m_vec});
    chk({tag, " wake"},  {31'd0, wake},   {31'd0, model_wake()});
  endtask

  task automatic quiet();
    nmi_n = 1'b1; ext1_n = 1'b1; ext1_lvl = 1'b0; ext2 = 1'b1; ext2_rise = 1'b0;
    tmr = 1'b0; adc = 1'b0; glb = 1'b1; en = 4'hF; bnd = 1'b1; reti = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick("R1 reset");
    tick("R1 reset");
    rst_n = 1'b1;
    tick("R1 release");
  endtask

  task automatic ret_once(input string tag);
    reti = 1'b1; tick(tag); reti = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    quiet();
    rst_n = 1'b0;
    @(negedge clk);
    do_reset();
    // R1: reset values
    chk("R1 vec after reset", {20'd0, vec_addr}, 32'hFFE);
    chk("R1 take after reset", {31'd0, take}, 32'd0);
    chk("R12 idle code", {30'd0, insvc}, 32'd0);

    // R8: timer underflow edge, taken one cycle after capture
    tmr = 1'b1; tick("R8 capture");
    tmr = 1'b0; tick("R8 take");
    chk("R8 timer vector", {20'd0, vec_addr}, 32'hFF4);
    chk("R12 periph code", {30'd0, insvc}, 32'd1);

    // R2: NMI preempts the peripheral handler
    nmi_n = 1'b0; tick("R2 capture");
    tick("R2 take");
    chk("R2 nmi vector", {20'd0, vec_addr}, 32'hFFC);
    chk("R12 nmi code", {30'd0, insvc}, 32'd2);
    // R3: second NMI held while the first is in service
    nmi_n = 1'b1; tick("R3 line high");
    nmi_n = 1'b0; tick("R3 capture");
    tick("R3 held");
    chk("R3 no self preempt", {31'd0, take}, 32'd0);
    // R10: return to preempted peripheral, then NMI held one is taken
    ret_once("R10 nmi return");
    chk("R10 back to periph", {30'd0, insvc}, 32'd1);
    tick("R3 taken after return");
    chk("R3 held nmi taken", {20'd0, vec_addr}, 32'hFFC);
    ret_once("R10 nmi return 2");
    ret_once("R10 periph return");
    chk("R10 idle", {30'd0, insvc}, 32'd0);
    nmi_n = 1'b1; tick("R2 line high");

    // R4: simultaneous timer and conversion requests, lower number first
    tmr = 1'b1; adc = 1'b1; tick("R4 capture");
    tmr = 1'b0; adc = 1'b0; tick("R4 first");
    chk("R4 lower vector first", {20'd0, vec_addr}, 32'hFF4);
    ret_once("R4 return");
    tick("R4 second");
    chk("R4 conversion vector", {20'd0, vec_addr}, 32'hFF6);
    ret_once("R4 return 2");
    // R4: disabled vector waits
    en = 4'b1011; tmr = 1'b1; tick("R4 masked capture");
    tmr = 1'b0; tick("R4 masked");
    chk("R4 masked no take", {31'd0, take}, 32'd0);
    en = 4'hF; tick("R4 unmasked");
    chk("R4 unmasked take", {20'd0, vec_addr}, 32'hFF4);
    ret_once("R4 return 3");

    // R5: level mode pulse lost while boundary low
    ext1_lvl = 1'b1; bnd = 1'b0; ext1_n = 1'b0; tick("R5 low");
    ext1_n = 1'b1; tick("R5 high");
    bnd = 1'b1; tick("R5 open");
    chk("R5 lost pulse", {31'd0, take}, 32'd0);
    ext1_n = 1'b0; tick("R5 level take");
    chk("R5 level vector", {20'd0, vec_addr}, 32'hFF0);
    ext1_n = 1'b1; ret_once("R5 return");

    // R6 and R9: edge mode pulse held across boundary low
    ext1_lvl = 1'b0; bnd = 1'b0; ext1_n = 1'b0; tick("R6 fall");
    ext1_n = 1'b1; tick("R9 hold");
    chk("R9 no take without boundary", {31'd0, take}, 32'd0);
    bnd = 1'b1; tick("R6 take");
    chk("R6 edge vector", {20'd0, vec_addr}, 32'hFF0);
    ret_once("R6 return");

    // R7: edge select on vector 2
    ext2 = 1'b0; tick("R7 fall sel0");
    tick("R7 take fall");
    chk("R7 falling taken", {20'd0, vec_addr}, 32'hFF2);
    ret_once("R7 return");
    ext2_rise = 1'b1; tick("R7 sel change");
    ext2 = 1'b1; tick("R7 rise");
    tick("R7 take rise");
    chk("R7 rising taken", {31'd0, take}, 32'd1);
    ret_once("R7 return 2");
    ext2 = 1'b0; tick("R7 fall ignored");
    tick("R7 fall ignored 2");
    chk("R7 opposite edge ignored", {31'd0, take}, 32'd0);
    ext2_rise = 1'b0; ext2 = 1'b1; tick("R7 restore");

    // R11: global enable low blocks maskable and wake, NMI still taken
    glb = 1'b0; adc = 1'b1; tick("R11 capture");
    adc = 1'b0; tick("R11 blocked");
    chk("R11 wake low", {31'd0, wake}, 32'd0);
    chk("R11 no maskable take", {31'd0, take}, 32'd0);
    nmi_n = 1'b0; tick("R11 nmi capture");
    chk("R11 nmi no wake", {31'd0, wake}, 32'd0);
    tick("R11 nmi take");
    chk("R11 nmi taken", {20'd0, vec_addr}, 32'hFFC);
    // R1: reset during the NMI handler
    nmi_n = 1'b1; glb = 1'b1;
    do_reset();
    chk("R1 reset clears nmi handler", {30'd0, insvc}, 32'd0);
    chk("R1 reset drops pending", {31'd0, wake}, 32'd0);

    // Random phase, checked every cycle against the model
    for (int c = 0; c < 6000; c++) begin
      if ($urandom_range(99) < 4)   nmi_n = ~nmi_n;
      if ($urandom_range(99) < 10)  ext1_n = ~ext1_n;
      if ($urandom_range(99) < 2)   ext1_lvl = ~ext1_lvl;
      if ($urandom_range(99) < 10)  ext2 = ~ext2;
      if ($urandom_range(99) < 2)   ext2_rise = ~ext2_rise;
      tmr  = ($urandom_range(99) < 6);
      adc  = ($urandom_range(99) < 6);
      glb  = ($urandom_range(99) < 85);
      if ($urandom_range(99) < 3)   en = 4'($urandom_range(15));
      bnd  = ($urandom_range(99) < 70);
      reti = (m_ins != 2'b00) && ($urandom_range(99) < 20);
      rst_n = !($urandom_range(999) < 2);
      tick("R4 random");
    end
    rst_n = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule